// File: doc/BRIEF.md
# Keyed Write-Lock Register Guard

This block sits beside a configuration register file and decides, write by write, whether a register write may go through. It holds one 16-bit protection word. The word has three fields: a 14-bit key in bits 15:2, a bit 1 that is always zero, and a lock flag in bit 0. A register bus drives an address, write data, a write strobe and a read strobe into the block. The block returns read-back data for the protection word and a combinational permit signal that gates writes to every other supported register.

While the lock flag is clear, software may write a new key, and the same write may also set the lock. Once the block is locked, every write to another register is dropped. A write that clears the lock takes effect only when its key field equals the stored key. Any other write to the protection word while locked changes nothing. Reads are never blocked.

Supported registers are addresses 0 to NUM_REGS-1. PROT_ADDR, one of those addresses, holds the protection word.

Top module: `wlg_lock_guard`

## Requirements
- R1: After reset the stored key is KEY_RESET (default 0x2AAA) and the lock flag is 0, so a read of PROT_ADDR returns 0xAAA8.
- R2: A read strobe at PROT_ADDR returns {key, 1'b0, lock} on rd_data one cycle after the strobe edge. A read of any other address returns 0. rd_data holds until the next read.
- R3: While unlocked, a write to PROT_ADDR loads wr_data[15:2] as the key and wr_data[0] as the lock flag, both in the same write.
- R4: While locked, a write to PROT_ADDR with wr_data[0]=0 and wr_data[15:2] equal to the stored key clears the lock and leaves the key unchanged.
- R5: While locked, a write to PROT_ADDR whose key field differs from the stored key changes neither the key nor the lock flag.
- R6: While locked, a write to PROT_ADDR with a matching key and wr_data[0]=1 leaves the block locked and the key unchanged.
- R7: wr_permit is 1 in the same cycle when wr_en is 1, the address is below NUM_REGS and is not PROT_ADDR, and the block is unlocked.
- R8: wr_permit is 0 while locked, for PROT_ADDR, for addresses at or above NUM_REGS, and whenever wr_en is 0.
- R9: Reads of the protection word work in both lock states.
- R10: Bit 1 of the protection word always reads 0, whatever value was written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register address for the read or write |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read-back data |
| wr_permit | output | 1 | Combinational write permit for the other registers |

## Verification
wr_permit is combinational, so the bench checks it in the same cycle as the strobe, after driving inputs on the falling edge. A change to the protection word becomes visible only through a read. The read strobe is captured on the next rising edge, and rd_data is sampled on the falling edge that follows. Each write is therefore checked two edges after it is applied. The unlock path is checked with a sweep over all 16384 key values against a locked word, and only the matching value is expected to unlock.

// File: rtl/wlg_pkg.sv
package wlg_pkg;
    localparam int WORD_W   = 16;
    localparam int LOCK_POS = 0;
    localparam int RSVD_POS = 1;
    localparam int KEY_LSB  = 2;
    localparam int KEY_W    = WORD_W - KEY_LSB;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             lock;
    } guard_state_t;
endpackage

// File: rtl/wlg_addr_dec.sv
module wlg_addr_dec #(
    parameter int ADDR_W    = 4,
    parameter int NUM_REGS  = 8,
    parameter int PROT_ADDR = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_prot,
    output logic              hit_other
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);
    localparam logic [ADDR_W-1:0] PADDR = ADDR_W'(PROT_ADDR);

    logic in_range;

    always_comb begin
        in_range  = ({1'b0, addr} < LIMIT);
        hit_prot  = (addr == PADDR);
        hit_other = in_range && !hit_prot;
    end
endmodule

// File: rtl/wlg_key_match.sv
module wlg_key_match #(
    parameter int KEY_W = 14
) (
    input  logic [KEY_W-1:0] key_in,
    input  logic [KEY_W-1:0] key_ref,
    output logic             match
);
    logic [KEY_W-1:0] bit_eq;

    for (genvar i = 0; i < KEY_W; i++) begin : g_bit
        assign bit_eq[i] = ~(key_in[i] ^ key_ref[i]);
    end

    assign match = &bit_eq;
endmodule

// File: rtl/wlg_prot_state.sv
module wlg_prot_state
    import wlg_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY_RESET = 14'h2AAA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_prot,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             wr_lock,
    input  logic             key_ok,
    output guard_state_t     state_q
);
    guard_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (wr_prot) begin
            if (!state_q.lock) begin
                state_d.key  = wr_key;
                state_d.lock = wr_lock;
            end else if (key_ok && !wr_lock) begin
                state_d.lock = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.key  <= KEY_RESET;
            state_q.lock <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    // R3: unlocked write loads both fields
    a_r3_unlocked_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prot && !state_q.lock) |=> (state_q.key == $past(wr_key)) && (state_q.lock == $past(wr_lock)));
    // R4: matching unlock clears lock
    a_r4_key_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prot && state_q.lock && key_ok && !wr_lock) |=> (!state_q.lock && $stable(state_q.key)));
    // R5: wrong key leaves state alone
    a_r5_wrong_key_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prot && state_q.lock && !key_ok) |=> ($stable(state_q.key) && state_q.lock));
    // R6: relock with matching key keeps state
    a_r6_relock_keeps_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prot && state_q.lock && wr_lock) |=> ($stable(state_q.key) && state_q.lock));
endmodule

// File: rtl/wlg_read_port.sv
module wlg_read_port
    import wlg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              hit_prot,
    input  guard_state_t      state,
    output logic [WORD_W-1:0] rd_data_q
);
    logic [WORD_W-1:0] rd_data_d;
    logic [WORD_W-1:0] word;

    always_comb begin
        word            = '0;
        word[WORD_W-1:KEY_LSB] = state.key;
        word[LOCK_POS]  = state.lock;
        rd_data_d       = rd_data_q;
        if (rd_en) begin
            rd_data_d = hit_prot ? word : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else begin
            rd_data_q <= rd_data_d;
        end
    end

    // R10: reserved bit never reads back as 1
    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_q[RSVD_POS] == 1'b0);
    // R2: read result appears one cycle after strobe
    a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_prot) |=> (rd_data_q[LOCK_POS] == $past(state.lock)));
endmodule

// File: rtl/wlg_lock_guard.sv
module wlg_lock_guard
    import wlg_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int NUM_REGS  = 8,
    parameter int PROT_ADDR = 0,
    parameter logic [13:0] KEY_RESET = 14'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [15:0]       rd_data,
    output logic              wr_permit
);
    logic         hit_prot;
    logic         hit_other;
    logic         key_ok;
    logic         wr_prot;
    logic         rsvd_in;
    guard_state_t state_q;

    wlg_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .PROT_ADDR(PROT_ADDR)
    ) u_dec (
        .addr     (addr),
        .hit_prot (hit_prot),
        .hit_other(hit_other)
    );

    wlg_key_match #(.KEY_W(KEY_W)) u_match (
        .key_in (wr_data[WORD_W-1:KEY_LSB]),
        .key_ref(state_q.key),
        .match  (key_ok)
    );

    assign wr_prot = wr_en && hit_prot;
    assign rsvd_in = wr_data[RSVD_POS];

    wlg_prot_state #(.KEY_RESET(KEY_RESET)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_prot(wr_prot),
        .wr_key (wr_data[WORD_W-1:KEY_LSB]),
        .wr_lock(wr_data[LOCK_POS]),
        .key_ok (key_ok),
        .state_q(state_q)
    );

    wlg_read_port u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .hit_prot (hit_prot),
        .state    (state_q),
        .rd_data_q(rd_data)
    );

    assign wr_permit = wr_en && hit_other && !state_q.lock;

    // R8: nothing passes while locked
    a_r8_no_permit_locked: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.lock |-> !wr_permit);
    // R8: the protection word itself is never permitted downstream
    a_r8_no_permit_prot: assert property (@(posedge clk) disable iff (!rst_n)
        hit_prot |-> !wr_permit);
    // R10: a reserved-bit write leaves the read-back bit at zero
    a_r10_rsvd_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prot && rsvd_in) |=> !rd_data[RSVD_POS]);
endmodule

// File: tb/wlg_lock_guard_bench.sv
module wlg_lock_guard_bench;
    localparam int AW = 4;
    localparam int NR = 8;
    localparam int PA = 0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wr_data = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [15:0]   rd_data;
    logic          wr_permit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [13:0] m_key;
    logic        m_lock;

    always #4 clk = ~clk;

    wlg_lock_guard #(.ADDR_W(AW), .NUM_REGS(NR), .PROT_ADDR(PA)) u_wlg_lock_guard (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .wr_permit(wr_permit)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] m_word();
        return {m_key, 1'b0, m_lock};
    endfunction

    // write: drive at negedge, check permit mid-cycle, commit at posedge
    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input string req);
        logic exp_p;
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        #1;
        exp_p = (int'(a) < NR) && (int'(a) != PA) && !m_lock;
        check(req, {15'd0, wr_permit}, {15'd0, exp_p});
        if (int'(a) == PA) begin
            if (!m_lock) begin
                m_key = d[15:2]; m_lock = d[0];
            end else if (d[15:2] == m_key && !d[0]) begin
                m_lock = 1'b0;
            end
        end
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req);
        logic [15:0] exp_d;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_d = (int'(a) == PA) ? m_word() : 16'h0;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, exp_d);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_key = 14'h2AAA; m_lock = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset value, R2 format and latency
        do_read(AW'(PA), "R1");
        check("R1", rd_data, 16'hAAA8);
        // R2: non-protection reads give zero
        do_read(AW'(3), "R2");
        // R7/R8: permit sweep over every address, unlocked
        for (int a = 0; a < (1 << AW); a++) begin
            @(negedge clk);
            addr = AW'(a); wr_en = 1'b0; #1;
            check("R8", {15'd0, wr_permit}, 16'h0);
            do_write(AW'(a == PA ? 1 : a), 16'h1234, "R7");
        end
        // R3 + R10: unlocked load with reserved bit set, stays unlocked
        do_write(AW'(PA), {14'h1357, 1'b1, 1'b0}, "R3");
        do_read(AW'(PA), "R10");
        // R3: load key and lock together
        do_write(AW'(PA), {14'h0F0F, 1'b0, 1'b1}, "R3");
        do_read(AW'(PA), "R9");
        // R8: permit sweep, locked
        for (int a = 0; a < (1 << AW); a++) begin
            do_write(AW'(a), 16'hFFFF, "R8");
        end
        do_read(AW'(PA), "R9");
        // R6: matching key with lock bit 1
        do_write(AW'(PA), {14'h0F0F, 1'b1, 1'b1}, "R6");
        do_read(AW'(PA), "R6");
        // R4/R5: exhaustive unlock attempts
        for (int k = 0; k < (1 << 14); k++) begin
            do_write(AW'(PA), {14'(k), 1'b1, 1'b0}, (14'(k) == 14'h0F0F) ? "R4" : "R5");
            if (k % 512 == 0 || 14'(k) == 14'h0F0F) do_read(AW'(PA), "R5");
            if (!m_lock) begin
                do_read(AW'(PA), "R4");
                do_write(AW'(PA), {14'h0F0F, 1'b0, 1'b1}, "R3");
            end
        end
        do_read(AW'(PA), "R5");
        check("R5", {15'd0, m_lock}, 16'h1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule